// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from one clock. A small register file on a plain write-enable and address bus holds a shared control word and one configuration word per channel. The control word gives each channel an enable bit and a two-bit prescale code. The configuration word packs a period length, counted in prescaled steps and called the timebase, together with a duty length in the same steps.

While a channel is enabled and its timebase is non-zero, its output goes high at the start of each period. It stays high for duty steps and is low for the rest of the timebase steps. New period and duty values are taken up only when a period ends, so a running waveform never shows a clipped pulse. Reads are combinational from the address.

Top module: `pwm_quad`

## Requirements
- R1: Each of the four channels runs on its own. With timebase T > 0 and duty D < T, the output is high for the first D steps and low for the remaining T-D steps of every T-step period. A period starts with its high part.
- R2: The control word is at offset 0x00. Bit n enables channel n. Bits [2n+5:2n+4] hold the prescale code for channel n.
- R3: One step lasts 1 clock for prescale code 0, 8 for code 1, 64 for code 2 and 512 for code 3. Code 3 cascades the divide-by-8 stage into the divide-by-64 stage.
- R4: The configuration word of channel n is at offset 0x04+4n. The timebase is in bits [7:0] and the duty is in bits [23:16].
- R5: A duty equal to or greater than a non-zero timebase holds the output high for as long as the channel is enabled.
- R6: A duty of 0 holds the output low.
- R7: A disabled channel drives its output low and holds its counters at zero. Enabling it again starts a new period from its first step.
- R8: A timebase or duty written while the channel runs is used from the next period boundary on. The period in progress finishes with the old values.
- R9: A timebase of 0 leaves the channel idle with its output low.
- R10: Each register reads back the last value written to its implemented bits. All other bits read as zero.
- R11: Offsets other than 0x00 and 0x04 to 0x10 read as zero, and writes to them change no register.
- R12: After reset every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at addr (combinational) |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
A write takes effect on the rising edge that samples wr_en. The enable bit, the prescale code and the stored configuration change at that edge. Read data is combinational from the address, so the bench checks rdata in the same cycle it sets the address, away from the clock edge.

The outputs are combinational from the counters. Each output therefore reflects the state after the last rising edge. The bench steps its reference model on every rising edge, using the inputs it drove at the preceding falling edge, and compares all four outputs two time units later.

Timebase and duty changes only show in the output after the period in progress has ended. The model follows the same boundary rule, so every per-cycle comparison covers the one-period delay, including at the 512-clock step length.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    localparam int TB_W    = 8;
    localparam int CODE_W  = 2;
    localparam int STG_A_W = 3;
    localparam int STG_B_W = 6;
    localparam int DUTY_LSB = 16;
    localparam int CODE_LSB = 4;

    typedef enum logic [CODE_W-1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV8   = 2'd1,
        PS_DIV64  = 2'd2,
        PS_DIV512 = 2'd3
    } ps_code_e;

    typedef struct packed {
        logic [TB_W-1:0] duty;
        logic [TB_W-1:0] tb;
    } chan_cfg_t;

    function automatic logic [31:0] cfg_to_word(chan_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[TB_W-1:0] = c.tb;
        w[DUTY_LSB +: TB_W] = c.duty;
        return w;
    endfunction

    function automatic int cfg_offset(int ch);
        return 4 + 4 * ch;
    endfunction

endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
    import pwmq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NCH-1:0]                en_o,
    output logic [NCH-1:0][CODE_W-1:0]    code_o,
    output chan_cfg_t [NCH-1:0]           cfg_o
);

    logic [NCH-1:0]             en_q;
    logic [NCH-1:0][CODE_W-1:0] code_q;
    chan_cfg_t [NCH-1:0]        cfg_q;
    logic                       hit_ctrl;
    logic [NCH-1:0]             hit_cfg;
    logic                       unmapped;

    assign hit_ctrl = (addr == '0);

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        assign hit_cfg[n] = (int'(addr) == cfg_offset(n));
    end

    assign unmapped = !hit_ctrl && (hit_cfg == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            code_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            if (hit_ctrl) begin
                en_q <= wdata[NCH-1:0];
                for (int n = 0; n < NCH; n++)
                    code_q[n] <= wdata[CODE_LSB + CODE_W*n +: CODE_W];
            end
            for (int n = 0; n < NCH; n++) begin
                if (hit_cfg[n]) begin
                    cfg_q[n].tb   <= wdata[TB_W-1:0];
                    cfg_q[n].duty <= wdata[DUTY_LSB +: TB_W];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[NCH-1:0] = en_q;
            for (int n = 0; n < NCH; n++)
                rdata[CODE_LSB + CODE_W*n +: CODE_W] = code_q[n];
        end
        for (int n = 0; n < NCH; n++)
            if (hit_cfg[n]) rdata = cfg_to_word(cfg_q[n]);
    end

    assign en_o   = en_q;
    assign code_o = code_q;
    assign cfg_o  = cfg_q;

    // R11
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && unmapped) |=> ($stable(en_q) && $stable(code_q) && $stable(cfg_q)));

    // R10
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_ctrl) |=> (en_q == $past(wdata[NCH-1:0])));

endmodule

// File: rtl/pwmq_prescale.sv
module pwmq_prescale
    import pwmq_pkg::*;
#(
    parameter int A_W = STG_A_W,
    parameter int B_W = STG_B_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              step
);

    logic [A_W-1:0] a_q;
    logic [B_W-1:0] b_q;
    logic           a_wrap;
    logic           b_tick;

    assign a_wrap = &a_q;
    // the second stage counts first-stage wraps when both are selected
    assign b_tick = code[0] ? a_wrap : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (code[0]) a_q <= a_q + 1'b1;
            if (code[1] && b_tick) b_q <= b_q + 1'b1;
        end
    end

    assign step = en && (code[0] ? a_wrap : 1'b1) && (code[1] ? &b_q : 1'b1);

    // R3
    step_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && code != PS_DIV1 && step) |=> (!step || code != $past(code)));

endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan
    import pwmq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      step,
    input  chan_cfg_t cfg_in,
    output logic      out
);

    logic [TB_W-1:0] cnt_q;
    logic [TB_W-1:0] tb_q;
    logic [TB_W-1:0] du_q;
    logic            idle;
    logic            last;

    assign idle = (tb_q == '0);
    assign last = (cnt_q == tb_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tb_q  <= '0;
            du_q  <= '0;
        end else if (!en || idle) begin
            cnt_q <= '0;
            tb_q  <= cfg_in.tb;
            du_q  <= cfg_in.duty;
        end else if (step) begin
            if (last) begin
                cnt_q <= '0;
                tb_q  <= cfg_in.tb;
                du_q  <= cfg_in.duty;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign out = en && !idle && (cnt_q < du_q);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !idle) |-> (cnt_q < tb_q));

    // R8
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !idle && !(step && last)) |=> ($stable(tb_q) && $stable(du_q)));

    // R7
    off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !out);

    // R5
    full_high_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !idle && du_q >= tb_q) |-> out);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwmq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out
);

    localparam int CTRL_BITS = CODE_LSB + CODE_W * NCH;

    logic [NCH-1:0]             en;
    logic [NCH-1:0][CODE_W-1:0] code;
    chan_cfg_t [NCH-1:0]        cfg;
    logic [NCH-1:0]             step;

    pwmq_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .en_o   (en),
        .code_o (code),
        .cfg_o  (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwmq_prescale u_ps (
            .clk  (clk),
            .rst  (rst),
            .en   (en[c]),
            .code (code[c]),
            .step (step[c])
        );
        pwmq_chan u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (en[c]),
            .step   (step[c]),
            .cfg_in (cfg[c]),
            .out    (pwm_out[c])
        );
    end

    initial begin
        if (CTRL_BITS > DATA_W) $error("control word does not fit the data width");
    end

    // R12
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (pwm_out == '0));

endmodule

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pwm_quad dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    // behavioural reference state
    int    m_pc[4], m_cnt[4], m_tb[4], m_du[4], m_code[4], m_ctb[4], m_cdu[4];
    bit    m_en[4];
    string tag[4];

    function automatic int div_of(int c);
        case (c)
            0: return 1;
            1: return 8;
            2: return 64;
            default: return 512;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_pc[c] = 0; m_cnt[c] = 0; m_tb[c] = 0; m_du[c] = 0;
            m_code[c] = 0; m_ctb[c] = 0; m_cdu[c] = 0; m_en[c] = 0;
        end
    endtask

    task automatic model_edge();
        for (int c = 0; c < 4; c++) begin
            if (!m_en[c]) begin
                m_pc[c] = 0; m_cnt[c] = 0; m_tb[c] = m_ctb[c]; m_du[c] = m_cdu[c];
            end else begin
                bit s;
                s = (m_pc[c] == div_of(m_code[c]) - 1);
                m_pc[c] = s ? 0 : m_pc[c] + 1;
                if (m_tb[c] == 0) begin
                    m_cnt[c] = 0; m_tb[c] = m_ctb[c]; m_du[c] = m_cdu[c];
                end else if (s) begin
                    if (m_cnt[c] == m_tb[c] - 1) begin
                        m_cnt[c] = 0; m_tb[c] = m_ctb[c]; m_du[c] = m_cdu[c];
                    end else begin
                        m_cnt[c] = m_cnt[c] + 1;
                    end
                end
            end
        end
        if (wr_en) begin
            if (addr == 8'h00) begin
                for (int c = 0; c < 4; c++) begin
                    m_en[c]   = wdata[c];
                    m_code[c] = int'(wdata[4 + 2*c +: 2]);
                end
            end
            for (int c = 0; c < 4; c++) begin
                if (int'(addr) == 4 + 4*c) begin
                    m_ctb[c] = int'(wdata[7:0]);
                    m_cdu[c] = int'(wdata[23:16]);
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else model_edge();
        #2;
        for (int c = 0; c < 4; c++) begin
            bit exp_o;
            exp_o = m_en[c] && (m_tb[c] != 0) && (m_cnt[c] < m_du[c]);
            checks++;
            if (pwm_out[c] !== exp_o) begin
                errors++;
                $display("FAIL %s ch%0d out actual=%b expected=%b at %0t",
                         rst ? "R12" : tag[c], c, pwm_out[c], exp_o, $time);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp_v, input string rq);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp_v) begin
            errors++;
            $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", rq, a, rdata, exp_v);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_tags(input string t0, input string t1, input string t2, input string t3);
        tag[0] = t0; tag[1] = t1; tag[2] = t2; tag[3] = t3;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_tags("R12", "R12", "R12", "R12");
        run(4);
        rst = 1'b0;
        // R12: all registers clear after reset
        rd_chk(8'h00, 32'h0, "R12");
        rd_chk(8'h04, 32'h0, "R12");
        rd_chk(8'h10, 32'h0, "R12");

        // R4 / R10: configuration words, unused bits dropped
        wr(8'h04, 32'hFF03_FF0A);
        wr(8'h08, 32'h0004_0004);
        wr(8'h0C, 32'h0000_0005);
        wr(8'h10, 32'h0007_0000);
        rd_chk(8'h04, 32'h0003_000A, "R10");
        rd_chk(8'h08, 32'h0004_0004, "R4");
        rd_chk(8'h0C, 32'h0000_0005, "R4");
        rd_chk(8'h10, 32'h0007_0000, "R4");

        // R11: unmapped offsets
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h0, "R11");
        rd_chk(8'h00, 32'h0, "R11");
        rd_chk(8'h04, 32'h0003_000A, "R11");
        rd_chk(8'h10, 32'h0007_0000, "R11");

        // R1 R5 R6 R9 with R2 enables; ch1 uses code 1
        set_tags("R1", "R5", "R6", "R9");
        wr(8'h00, 32'hFFFF_F04F);
        rd_chk(8'h00, 32'h0000_004F, "R2");
        run(150);

        // R8: change period and duty of ch0 mid-period
        set_tags("R8", "R5", "R6", "R9");
        wr(8'h04, 32'h0007_0006);
        run(60);
        wr(8'h04, 32'h0002_0009);
        run(40);

        // R7: disable ch0, then enable again
        set_tags("R7", "R7", "R6", "R9");
        wr(8'h00, 32'h0000_004E);
        run(20);
        wr(8'h00, 32'h0000_004F);
        run(40);

        // R3: all prescale codes, set while disabled
        wr(8'h00, 32'h0);
        set_tags("R3", "R3", "R3", "R2");
        wr(8'h04, 32'h0001_0002);
        wr(8'h08, 32'h0002_0003);
        wr(8'h0C, 32'h0001_0003);
        wr(8'h10, 32'h0001_0002);
        wr(8'h00, 32'h0000_01BF);
        rd_chk(8'h00, 32'h0000_01BF, "R2");
        run(2600);

        // R6 / R9 at the end: zero duty and zero timebase on running channels
        set_tags("R6", "R9", "R3", "R2");
        wr(8'h04, 32'h0000_0002);
        wr(8'h08, 32'h0005_0000);
        run(2200);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule